// File: doc/BRIEF.md
# Banked Configuration Register Space

This block provides a 32-location, 8-bit register space behind a simple synchronous read/write port. The top location, 0x1F, holds a bank selector that every bank shares. The other 31 locations, 0x00 to 0x1E, reach whichever of thirteen banks the selector currently names. The banks are a primary bank, a secondary bank, a channel-common bank, a bit-error-test bank, a global test bank and eight per-channel test banks. Rewriting the selector changes what every lower address means from the next access on.

Each bank has full 31-byte storage. A few locations are decoded into configuration outputs: per-channel transmitter output enables, per-channel 2048 kHz sync-mode enables, a transmit clock-source select, and a per-channel short-circuit override flag with a 5-bit current limit. Reserved bits in those locations are cleared as they are written, so they read back as zero. Selector values that name no bank give an empty space: reads return zero and writes are dropped. Read data is registered.

Top module: `banked_regfile`

## Requirements
- R1: After reset the selector is 0x00, every bank location is 0x00, all configuration outputs are 0 and rdata_o is 0x00.
- R2: Address 0x1F stores all 8 written bits as the selector and reads back the stored value whatever bank is selected.
- R3: Selector codes map to banks as follows. 0x00 is primary, 0xAA is secondary, 0x01 is channel-common, 0x02 is bit-error-test and 0x03 is global test. 0x04+k is the test bank of channel k, for k = 0 to 7. The same address in different banks reaches separate storage.
- R4: While the selector holds any other code, reads of 0x00 to 0x1E return 0x00 and writes to them change no bank.
- R5: A read strobe with an address loads rdata_o at the next clock edge. rdata_o holds while no read is strobed. A read and a write to the same location in one cycle returns the contents from before the write.
- R6: Location 0x08 of the channel-common bank drives sync_en_o, with bit k for channel k (1 = 2048 kHz sync mode, 0 = normal).
- R7: Location 0x12 of the primary bank drives tx_oe_o, with bit k for channel k.
- R8: Bit 4 of location 0x07 in the global test bank drives clk_sel_o (0 = master clock, 1 = channel transmit or recovered clock). The other bits of that location read 0.
- R9: Location 0x05 of channel k's test bank drives scd_ovr_o[k] from bit 5 and scd_limit_o[5k+4:5k] from bits 4:0. Bits 7:6 read 0.
- R10: Every other location in every bank stores and returns all 8 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 5 | Location address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| sync_en_o | output | NUM_CH | Per-channel 2048 kHz sync-mode enable |
| tx_oe_o | output | NUM_CH | Per-channel transmitter output enable |
| clk_sel_o | output | 1 | Transmit clock-source select for special modes |
| scd_ovr_o | output | NUM_CH | Per-channel short-circuit limit override |
| scd_limit_o | output | 5*NUM_CH | Per-channel short-circuit current limit, 5 bits each |

## Verification
The bench loads a distinct pattern into every location of every bank. It then steps the selector through all 256 codes and reads all 31 locations under each one. A decoder that aliased the secondary code onto another bank, or that let an unassigned code fall through to a real bank, would return another bank's pattern instead of the expected byte or zero. Writing 0xFF everywhere under unassigned codes and then re-reading the real banks catches write paths that leak. Further checks target the reserved-bit positions of the clock-select and short-circuit locations, a read that collides with a write, and rdata_o holding between strobes. A design that masked reads instead of writes, or forwarded write data, would show up there.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int LIM_W = 5;

  // bank indices
  localparam int BK_PRI  = 0;
  localparam int BK_SEC  = 1;
  localparam int BK_COM  = 2;
  localparam int BK_BERT = 3;
  localparam int BK_GTST = 4;
  localparam int BK_CHT0 = 5;

  // selector codes
  localparam logic [DW-1:0] PTR_PRI  = 8'h00;
  localparam logic [DW-1:0] PTR_SEC  = 8'hAA;
  localparam logic [DW-1:0] PTR_COM  = 8'h01;
  localparam logic [DW-1:0] PTR_BERT = 8'h02;
  localparam logic [DW-1:0] PTR_GTST = 8'h03;
  localparam logic [DW-1:0] PTR_CHT0 = 8'h04;

  localparam logic [AW-1:0] A_PTR    = 5'h1F;
  localparam logic [AW-1:0] A_TXOE   = 5'h12;
  localparam logic [AW-1:0] A_SYNC   = 5'h08;
  localparam logic [AW-1:0] A_CLKSEL = 5'h07;
  localparam logic [AW-1:0] A_SCD    = 5'h05;
  localparam int CLKSEL_BIT = 4;

  function automatic logic [DW-1:0] wr_mask(int bank, logic [AW-1:0] a);
    if (bank == BK_GTST && a == A_CLKSEL) return 8'h10;
    if (bank >= BK_CHT0 && a == A_SCD)    return 8'h3F;
    return 8'hFF;
  endfunction
endpackage

// File: rtl/banked_regfile_ptr.sv
module banked_regfile_ptr
  import banked_regfile_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int BW     = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ptr_o,
  output logic          valid_o,
  output logic [BW-1:0] idx_o
);
  localparam logic [DW-1:0] PTR_CHT_END = DW'(int'(PTR_CHT0) + NUM_CH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_o <= PTR_PRI;
    else if (we_i) ptr_o <= wdata_i;
  end

  always_comb begin
    valid_o = 1'b1;
    idx_o   = '0;
    if (ptr_o == PTR_PRI)       idx_o = BW'(BK_PRI);
    else if (ptr_o == PTR_SEC)  idx_o = BW'(BK_SEC);
    else if (ptr_o == PTR_COM)  idx_o = BW'(BK_COM);
    else if (ptr_o == PTR_BERT) idx_o = BW'(BK_BERT);
    else if (ptr_o == PTR_GTST) idx_o = BW'(BK_GTST);
    else if (ptr_o >= PTR_CHT0 && ptr_o < PTR_CHT_END)
      idx_o = BW'(BK_CHT0) + BW'(ptr_o - PTR_CHT0);
    else valid_o = 1'b0;
  end
endmodule

// File: rtl/banked_regfile_bank.sv
module banked_regfile_bank
  import banked_regfile_pkg::*;
#(
  parameter int              BANK     = 0,
  parameter int              DEPTH    = 31,
  parameter logic [AW-1:0]   TAP_ADDR = '0,
  parameter int              TAP_LSB  = 0,
  parameter int              TAP_W    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [TAP_W-1:0] tap_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && addr_i < LAST) begin
      mem_q[addr_i] <= wdata_i & wr_mask(BANK, addr_i);
    end
  end

  assign rdata_o = (addr_i < LAST) ? mem_q[addr_i] : '0;
  assign tap_o   = mem_q[TAP_ADDR][TAP_LSB +: TAP_W];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_regfile_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    rd_en_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           rdata_o,
  output logic [NUM_CH-1:0]       sync_en_o,
  output logic [NUM_CH-1:0]       tx_oe_o,
  output logic                    clk_sel_o,
  output logic [NUM_CH-1:0]       scd_ovr_o,
  output logic [NUM_CH*LIM_W-1:0] scd_limit_o
);
  localparam int NB    = BK_CHT0 + NUM_CH;
  localparam int BW    = $clog2(NB);
  localparam int DEPTH = int'(A_PTR);

  logic [DW-1:0] ptr_w;
  logic          ptr_valid_w;
  logic [BW-1:0] ptr_idx_w;
  logic          ptr_hit_w;
  logic [DW-1:0] bank_rd_w [NB];
  logic [DW-1:0] rd_d;

  assign ptr_hit_w = (addr_i == A_PTR);

  banked_regfile_ptr #(.NUM_CH(NUM_CH), .BW(BW)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && ptr_hit_w),
    .wdata_i (wdata_i),
    .ptr_o   (ptr_w),
    .valid_o (ptr_valid_w),
    .idx_o   (ptr_idx_w)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [AW-1:0] TA =
      (b == BK_PRI)  ? A_TXOE   :
      (b == BK_COM)  ? A_SYNC   :
      (b == BK_GTST) ? A_CLKSEL :
      (b >= BK_CHT0) ? A_SCD    : '0;
    localparam int TL = (b == BK_GTST) ? CLKSEL_BIT : 0;
    localparam int TW =
      (b == BK_PRI || b == BK_COM) ? NUM_CH :
      (b >= BK_CHT0)               ? LIM_W + 1 : 1;

    logic [TW-1:0] tap_w;
    logic          bank_we;

    assign bank_we = wr_en_i && !ptr_hit_w && ptr_valid_w && (ptr_idx_w == BW'(b));

    banked_regfile_bank #(
      .BANK(b), .DEPTH(DEPTH), .TAP_ADDR(TA), .TAP_LSB(TL), .TAP_W(TW)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_we),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .rdata_o (bank_rd_w[b]),
      .tap_o   (tap_w)
    );

    if (b == BK_PRI) begin : g_oe
      assign tx_oe_o = tap_w;
    end else if (b == BK_COM) begin : g_sync
      assign sync_en_o = tap_w;
    end else if (b == BK_GTST) begin : g_clk
      assign clk_sel_o = tap_w[0];
    end else if (b >= BK_CHT0) begin : g_scd
      assign scd_ovr_o[b-BK_CHT0]                   = tap_w[LIM_W];
      assign scd_limit_o[(b-BK_CHT0)*LIM_W +: LIM_W] = tap_w[LIM_W-1:0];
    end else begin : g_plain
      logic tap_unused;
      assign tap_unused = tap_w[0];
    end
  end

  always_comb begin
    rd_d = '0;
    if (ptr_hit_w) rd_d = ptr_w;
    else if (ptr_valid_w) begin
      for (int b = 0; b < NB; b++)
        if (ptr_idx_w == BW'(b)) rd_d = bank_rd_w[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_d;
  end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import banked_regfile_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic                rd_en_i,
  input logic [AW-1:0]       addr_i,
  input logic [DW-1:0]       wdata_i,
  input logic [DW-1:0]       rdata_o,
  input logic [NUM_CH-1:0]   sync_en_o,
  input logic [NUM_CH-1:0]   tx_oe_o,
  input logic [DW-1:0]       ptr_w,
  input logic                ptr_valid_w
);
  localparam logic [DW-1:0] CHT_END = DW'(int'(PTR_CHT0) + NUM_CH);

  AST_PTR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == A_PTR |=> ptr_w == $past(wdata_i)); // R2

  AST_PTR_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == A_PTR |=> rdata_o == $past(ptr_w)); // R2

  AST_NO_BANK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i != A_PTR && !ptr_valid_w |=> rdata_o == '0); // R4

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R5

  AST_SYNC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == A_SYNC && ptr_w == PTR_COM) |=> $stable(sync_en_o)); // R6

  AST_OE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == A_TXOE && ptr_w == PTR_PRI) |=> $stable(tx_oe_o)); // R7

  AST_CLKSEL_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == A_CLKSEL && ptr_w == PTR_GTST |=> (rdata_o & 8'hEF) == '0); // R8

  AST_SCD_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == A_SCD && ptr_w >= PTR_CHT0 && ptr_w < CHT_END
    |=> rdata_o[7:6] == 2'b00); // R9
endmodule

bind banked_regfile banked_regfile_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .sync_en_o   (sync_en_o),
  .tx_oe_o     (tx_oe_o),
  .ptr_w       (ptr_w),
  .ptr_valid_w (ptr_valid_w)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  localparam int NCH = 8;
  localparam int NBK = 5 + NCH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NCH-1:0] sync_en, tx_oe, scd_ovr;
  logic clk_sel;
  logic [NCH*5-1:0] scd_limit;

  int total = 0, fails = 0;
  logic [7:0] exp_q [NBK][31];

  always #5 clk = ~clk;

  banked_regfile #(.NUM_CH(NCH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .sync_en_o(sync_en), .tx_oe_o(tx_oe), .clk_sel_o(clk_sel),
    .scd_ovr_o(scd_ovr), .scd_limit_o(scd_limit)
  );

  function automatic logic [7:0] code_of(int b);
    case (b)
      0: return 8'h00;
      1: return 8'hAA;
      2: return 8'h01;
      3: return 8'h02;
      4: return 8'h03;
      default: return 8'(b - 1);
    endcase
  endfunction

  function automatic int bank_of(logic [7:0] p);
    for (int b = 0; b < NBK; b++) if (code_of(b) == p) return b;
    return -1;
  endfunction

  function automatic logic [7:0] msk(int b, int a);
    if (b == 4 && a == 7) return 8'h10;
    if (b >= 5 && a == 5) return 8'h3F;
    return 8'hFF;
  endfunction

  function automatic string tag(int b, int a);
    if (b == 4 && a == 7)    return "R8";
    if (b >= 5 && a == 5)    return "R9";
    if (b == 2 && a == 8)    return "R6";
    if (b == 0 && a == 18)   return "R7";
    return "R3 R10";
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
    total++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic check_outputs(string req);
    logic [NCH-1:0] ov;
    logic [NCH*5-1:0] lim;
    for (int k = 0; k < NCH; k++) begin
      ov[k] = exp_q[5+k][5][5];
      lim[k*5 +: 5] = exp_q[5+k][5][4:0];
    end
    chk({req, " R7 tx_oe"}, 64'(tx_oe), 64'(exp_q[0][18][NCH-1:0]));
    chk({req, " R6 sync_en"}, 64'(sync_en), 64'(exp_q[2][8][NCH-1:0]));
    chk({req, " R8 clk_sel"}, 64'(clk_sel), 64'(exp_q[4][7][4]));
    chk({req, " R9 scd_ovr"}, 64'(scd_ovr), 64'(ov));
    chk({req, " R9 scd_limit"}, 64'(scd_limit), 64'(lim));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int b = 0; b < NBK; b++)
      for (int a = 0; a < 31; a++) exp_q[b][a] = '0;

    // R1 reset state
    #1;
    chk("R1 rdata", 64'(rdata), 64'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_outputs("R1");
    rd(5'h1F, d); chk("R1 selector", 64'(d), 64'h00);
    rd(5'h12, d); chk("R1 primary", 64'(d), 64'h00);

    // load patterns into every bank
    for (int b = 0; b < NBK; b++) begin
      wr(5'h1F, code_of(b));
      rd(5'h1F, d); chk("R2 selector readback", 64'(d), 64'(code_of(b)));
      for (int a = 0; a < 31; a++) begin
        logic [7:0] p;
        p = 8'((b * 37 + a * 11 + 5) ^ (a << 3));
        wr(5'(a), p);
        exp_q[b][a] = p & msk(b, a);
      end
    end
    check_outputs("load");

    // full selector sweep: reads everywhere, writes under unassigned codes
    for (int p = 0; p < 256; p++) begin
      int b;
      b = bank_of(8'(p));
      wr(5'h1F, 8'(p));
      rd(5'h1F, d); chk("R2 selector sweep", 64'(d), 64'(p));
      for (int a = 0; a < 31; a++) begin
        rd(5'(a), d);
        if (b < 0) chk("R4 empty read", 64'(d), 64'h0);
        else       chk(tag(b, a), 64'(d), 64'(exp_q[b][a]));
      end
      if (b < 0) begin
        for (int a = 0; a < 31; a++) wr(5'(a), 8'hFF);
        for (int a = 0; a < 31; a += 10) begin
          rd(5'(a), d); chk("R4 empty after write", 64'(d), 64'h0);
        end
      end
    end
    check_outputs("R4 after ignored writes");

    for (int b = 0; b < NBK; b++) begin
      wr(5'h1F, code_of(b));
      for (int a = 0; a < 31; a++) begin
        rd(5'(a), d); chk("R4 banks intact", 64'(d), 64'(exp_q[b][a]));
      end
    end

    // R8 clock select both ways
    wr(5'h1F, 8'h03);
    wr(5'h07, 8'hFF); exp_q[4][7] = 8'h10;
    chk("R8 clk_sel set", 64'(clk_sel), 64'h1);
    rd(5'h07, d); chk("R8 reserved cleared", 64'(d), 64'h10);
    wr(5'h07, 8'hEF); exp_q[4][7] = 8'h00;
    chk("R8 clk_sel clear", 64'(clk_sel), 64'h0);

    // R9 last channel test bank
    wr(5'h1F, 8'h0B);
    wr(5'h05, 8'hFF); exp_q[12][5] = 8'h3F;
    rd(5'h05, d); chk("R9 reserved 7:6", 64'(d), 64'h3F);
    check_outputs("R9 ch7");
    wr(5'h05, 8'hC0); exp_q[12][5] = 8'h00;
    check_outputs("R9 ch7 clear");

    // R6 sync enable, then same address in primary bank
    wr(5'h1F, 8'h01);
    wr(5'h08, 8'h81); exp_q[2][8] = 8'h81;
    chk("R6 sync_en", 64'(sync_en), 64'h81);
    wr(5'h1F, 8'h00);
    wr(5'h08, 8'h7E); exp_q[0][8] = 8'h7E;
    chk("R3 R6 other bank", 64'(sync_en), 64'h81);

    // R7 output enable
    wr(5'h12, 8'h5A); exp_q[0][18] = 8'h5A;
    chk("R7 tx_oe", 64'(tx_oe), 64'h5A);
    check_outputs("R7");

    // R5 read colliding with write, then hold
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 5'h03; wdata = 8'hC3;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R5 read-during-write old", 64'(rdata), 64'(exp_q[0][3]));
    exp_q[0][3] = 8'hC3;
    rd(5'h03, d); chk("R5 new value", 64'(d), 64'hC3);
    @(negedge clk); addr = 5'h12; wdata = 8'h00;
    @(negedge clk);
    chk("R5 hold without strobe", 64'(rdata), 64'hC3);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule